// File: doc/BRIEF.md
# Strap-Sampled Debug Test-Point Multiplexer

This block owns an 8-bit debug test-point bus whose low four pins double as power-on strap inputs. While the active-low park signal is low, the block holds its state cleared and leaves the bus undriven. After park rises, it leaves the low four pins as inputs and counts a fixed delay of about 1.5 µs. At the end of that delay it latches their levels as a 4-bit test-mode code, and it keeps that code until park falls again.

Once the code is latched, the block enables its output drivers. It then places one of three signal sets on all eight pins:
- a quiet all-zero pattern;
- a clock-debug pattern made of six internal clock taps framed by two constant-high bits;
- a calibration pattern carrying sync, color-wheel and reset-sequence markers.

Boards normally pull the straps low, so an unstrapped board reads code 0000 and the bus stays quiet.

Top module: `dbg_strap_mux`

## Requirements
- R1: While `park_n` is low at a clock edge, that edge clears the captured code, `tp_oe` and `cap_strobe`. `tp_out` reads 0 whenever `tp_oe` is low.
- R2: Treat the first rising clock edge with `park_n` high as edge 1. The strap value is captured on edge N, where N is the clock frequency in MHz times the delay in ns divided by 1000, rounded (150 by default). `cap_strobe` is high for exactly the one cycle after that edge.
- R3: `tp_oe` rises one cycle after `cap_strobe` rises. It then stays high until `park_n` falls.
- R4: With captured code 4'b0000, all eight `tp_out` bits are 0 and never toggle.
- R5: With captured code 4'b0101, `tp_out[0]` and `tp_out[7]` are 1, and `tp_out[6:1]` equals `clk_taps[5:0]`. The taps follow live.
- R6: With captured code 4'b1000, `tp_out[7:0]` equals `cal_sigs[7:0]`. The bit order is: bit0 vertical sync, bit1 delayed wheel index, bit2 sequence index, bit3 spoke marker, bit4 revolution marker, bits 7..5 reset-sequence aux bits 2..0.
- R7: Any other captured code drives `tp_out` to all zeros, exactly like 4'b0000.
- R8: Strap pin changes after capture have no effect on `mode_code` or `tp_out`.
- R9: If `park_n` falls before the capture, the delay restarts from zero on the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| park_n | input | 1 | Active-low park/reset, sampled synchronously |
| strap_in | input | 4 | Levels of the low four test-point pins |
| clk_taps | input | 6 | Internal clock-derived debug signals |
| cal_sigs | input | 8 | Internal calibration and sequence markers |
| tp_out | output | 8 | Test-point drive value |
| tp_oe | output | 1 | Test-point output enable |
| cap_strobe | output | 1 | One-cycle pulse when the strap code is captured |
| mode_code | output | 4 | Captured test-mode code |

## Verification
A delay counter that is off by one shows up as `cap_strobe` arriving one cycle early or late relative to the release of park. It also shifts `tp_oe` by the same amount, so the fault is visible within 151 cycles of release. A latch that keeps following the straps, or a wrong mode decode, changes `mode_code` and `tp_out` in the very cycle the strap or tap inputs change. A counter that is not cleared by park shows as a strobe that comes too early after a short park pulse.

// File: rtl/dbg_strap_pkg.sv
package dbg_strap_pkg;
    localparam int TP_W     = 8;
    localparam int STRAP_W  = 4;
    localparam int N_TAPS   = 6;

    typedef enum logic [STRAP_W-1:0] {
        MODE_QUIET = 4'b0000,
        MODE_CLKS  = 4'b0101,
        MODE_CAL   = 4'b1000
    } tp_mode_e;

    // Calibration marker bundle, bit 0 is the vertical sync marker.
    typedef struct packed {
        logic [2:0] seq_aux;
        logic       wheel_rev;
        logic       wheel_spoke;
        logic       seq_index;
        logic       wheel_idx_dly;
        logic       vsync;
    } cal_bundle_t;

    function automatic logic [TP_W-1:0] pick_tp(
        input logic [STRAP_W-1:0] code,
        input logic [N_TAPS-1:0]  taps,
        input cal_bundle_t        cal
    );
        logic [TP_W-1:0] v;
        case (code)
            MODE_CLKS: v = {1'b1, taps, 1'b1};
            MODE_CAL:  v = cal;
            default:   v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/strap_delay_timer.sv
module strap_delay_timer #(
    parameter int DELAY_CYC = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic fire
);
    localparam int CNT_W = $clog2(DELAY_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign fire = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (run && !fire)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/strap_code_latch.sv
module strap_code_latch
    import dbg_strap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [STRAP_W-1:0] strap,
    output logic               held,
    output logic               strobe,
    output logic               oe,
    output logic [STRAP_W-1:0] code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            strobe <= 1'b0;
            oe     <= 1'b0;
            code   <= '0;
        end else begin
            strobe <= fire;
            oe     <= held;
            if (fire) begin
                held <= 1'b1;
                code <= strap;
            end
        end
    end
endmodule

// File: rtl/tp_drive_mux.sv
module tp_drive_mux
    import dbg_strap_pkg::*;
(
    input  logic               oe,
    input  logic [STRAP_W-1:0] code,
    input  logic [N_TAPS-1:0]  taps,
    input  logic [TP_W-1:0]    cal_raw,
    output logic [TP_W-1:0]    drive
);
    cal_bundle_t cal;
    always_comb begin
        cal   = cal_bundle_t'(cal_raw);
        drive = oe ? pick_tp(code, taps, cal) : '0;
    end
endmodule

// File: rtl/dbg_strap_mux.sv
module dbg_strap_mux
    import dbg_strap_pkg::*;
#(
    parameter int CLK_FREQ_MHZ = 100,
    parameter int SAMPLE_NS    = 1500
) (
    input  logic               clk,
    input  logic               park_n,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic [N_TAPS-1:0]  clk_taps,
    input  logic [TP_W-1:0]    cal_sigs,
    output logic [TP_W-1:0]    tp_out,
    output logic               tp_oe,
    output logic               cap_strobe,
    output logic [STRAP_W-1:0] mode_code
);
    localparam int DELAY_RAW = (CLK_FREQ_MHZ * SAMPLE_NS + 500) / 1000;
    localparam int DELAY_CYC = (DELAY_RAW < 1) ? 1 : DELAY_RAW;

    logic rst;
    logic held;
    logic fire;

    assign rst = !park_n;

    strap_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (!held),
        .fire (fire)
    );

    strap_code_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .strap  (strap_in),
        .held   (held),
        .strobe (cap_strobe),
        .oe     (tp_oe),
        .code   (mode_code)
    );

    tp_drive_mux u_mux (
        .oe      (tp_oe),
        .code    (mode_code),
        .taps    (clk_taps),
        .cal_raw (cal_sigs),
        .drive   (tp_out)
    );
endmodule

// File: rtl/dbg_strap_mux_chk.sv
module dbg_strap_mux_chk (
    input logic       clk,
    input logic       park_n,
    input logic [3:0] strap_in,
    input logic [7:0] tp_out,
    input logic       tp_oe,
    input logic       cap_strobe,
    input logic [3:0] mode_code
);
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!park_n)
        cap_strobe |=> !cap_strobe);

    p_oe_follows_strobe_r3: assert property (@(posedge clk) disable iff (!park_n)
        cap_strobe |=> tp_oe);

    p_oe_rise_needs_strobe_r3: assert property (@(posedge clk) disable iff (!park_n)
        $rose(tp_oe) |-> $past(cap_strobe));

    p_code_held_r8: assert property (@(posedge clk) disable iff (!park_n)
        tp_oe |=> $stable(mode_code));

    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!park_n)
        !tp_oe |-> (tp_out == 8'h00));

    p_quiet_codes_r7: assert property (@(posedge clk) disable iff (!park_n)
        (tp_oe && mode_code != 4'b0101 && mode_code != 4'b1000) |-> (tp_out == 8'h00));

    p_clk_frame_r5: assert property (@(posedge clk) disable iff (!park_n)
        (tp_oe && mode_code == 4'b0101) |-> (tp_out[0] && tp_out[7]));
endmodule

bind dbg_strap_mux dbg_strap_mux_chk u_chk (.*);

// File: tb/tb_dbg_strap_mux.sv
`timescale 1ns/1ps
module tb_dbg_strap_mux;
    localparam int DLY = 150;

    logic       clk = 1'b0;
    logic       park_n = 1'b0;
    logic [3:0] strap_in = 4'h0;
    logic [5:0] clk_taps = 6'h0;
    logic [7:0] cal_sigs = 8'h0;
    logic [7:0] tp_out;
    logic       tp_oe;
    logic       cap_strobe;
    logic [3:0] mode_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbg_strap_mux dut (
        .clk(clk), .park_n(park_n), .strap_in(strap_in), .clk_taps(clk_taps),
        .cal_sigs(cal_sigs), .tp_out(tp_out), .tp_oe(tp_oe),
        .cap_strobe(cap_strobe), .mode_code(mode_code)
    );

    typedef struct packed {
        logic [3:0] strap;
        logic [5:0] taps;
        logic [7:0] cal;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 6'h2A, 8'hC3, 8'h00},   // R4
        '{4'b0101, 6'h2A, 8'hC3, 8'hD5},   // R5
        '{4'b0101, 6'h15, 8'h00, 8'hAB},   // R5
        '{4'b1000, 6'h3F, 8'hC3, 8'hC3},   // R6
        '{4'b1000, 6'h00, 8'h5A, 8'h5A},   // R6
        '{4'b1111, 6'h3F, 8'hFF, 8'h00},   // R7
        '{4'b0100, 6'h3F, 8'hFF, 8'h00},   // R7
        '{4'b1001, 6'h3F, 8'hFF, 8'h00}    // R7
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic park(input int cyc);
        @(negedge clk);
        park_n = 1'b0;
        repeat (cyc) @(negedge clk);
    endtask

    // Release park at a negedge and step to just before capture edge.
    task automatic release_to_edge(input logic [3:0] s);
        strap_in = s;
        park_n = 1'b1;
        repeat (DLY - 1) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 8'h00, 8'h01);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        strap_in = 4'b0101;
        clk_taps = 6'h3F;
        cal_sigs = 8'hFF;
        repeat (3) @(negedge clk);
        check(tp_oe == 0 && cap_strobe == 0 && mode_code == 0, "R1 reset state",
              {tp_oe, cap_strobe, 2'b0, mode_code}, 8'h00);
        check(tp_out == 8'h00, "R1 tp_out quiet in park", tp_out, 8'h00);

        for (int i = 0; i < NV; i++) begin
            park(3);
            clk_taps = VECS[i].taps;
            cal_sigs = VECS[i].cal;
            release_to_edge(VECS[i].strap);
            check(cap_strobe == 0 && tp_oe == 0, "R2 no early capture",
                  {6'b0, cap_strobe, tp_oe}, 8'h00);
            @(negedge clk);
            check(cap_strobe == 1, "R2 strobe on delay edge", {7'b0, cap_strobe}, 8'h01);
            check(mode_code == VECS[i].strap, "R2 captured code", {4'b0, mode_code}, {4'b0, VECS[i].strap});
            check(tp_oe == 0 && tp_out == 8'h00, "R3 oe still low at strobe", tp_out, 8'h00);
            @(negedge clk);
            check(cap_strobe == 0, "R2 strobe single cycle", {7'b0, cap_strobe}, 8'h00);
            check(tp_oe == 1, "R3 oe one cycle after strobe", {7'b0, tp_oe}, 8'h01);
            check(tp_out == VECS[i].exp, "R4/R5/R6/R7 mode output", tp_out, VECS[i].exp);
            repeat (5) @(negedge clk);
            check(tp_oe == 1, "R3 oe stays high", {7'b0, tp_oe}, 8'h01);
        end

        // R5 live taps
        park(2);
        clk_taps = 6'h00;
        release_to_edge(4'b0101);
        repeat (2) @(negedge clk);
        check(tp_out == 8'h81, "R5 taps zero", tp_out, 8'h81);
        clk_taps = 6'h3F; #1;
        check(tp_out == 8'hFF, "R5 taps all ones", tp_out, 8'hFF);
        clk_taps = 6'h01; #1;
        check(tp_out == 8'h83, "R5 tap0 on bit1", tp_out, 8'h83);

        // R8 strap change after capture ignored
        strap_in = 4'b1000;
        cal_sigs = 8'h00;
        repeat (4) @(negedge clk);
        check(mode_code == 4'b0101, "R8 code held", {4'b0, mode_code}, 8'h05);
        check(tp_out == 8'h83, "R8 output unchanged", tp_out, 8'h83);

        // R6 live calibration markers
        park(2);
        cal_sigs = 8'h01;
        release_to_edge(4'b1000);
        repeat (2) @(negedge clk);
        check(tp_out == 8'h01, "R6 vsync bit0", tp_out, 8'h01);
        cal_sigs = 8'h80; #1;
        check(tp_out == 8'h80, "R6 aux2 bit7", tp_out, 8'h80);

        // R4 quiet mode stays zero while inputs toggle
        park(2);
        release_to_edge(4'b0000);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            clk_taps = 6'(k * 21);
            cal_sigs = 8'(k * 85);
            @(negedge clk);
            check(tp_out == 8'h00, "R4 no toggling", tp_out, 8'h00);
        end

        // R9 restart of the delay after an early park
        park(2);
        strap_in = 4'b1000;
        park_n = 1'b1;
        repeat (100) @(negedge clk);
        park_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tp_oe == 0 && mode_code == 0, "R1 cleared by park", {3'b0, tp_oe, mode_code}, 8'h00);
        park_n = 1'b1;
        repeat (DLY - 1) @(negedge clk);
        check(cap_strobe == 0 && mode_code == 0, "R9 delay restarted",
              {3'b0, cap_strobe, mode_code}, 8'h00);
        @(negedge clk);
        check(cap_strobe == 1 && mode_code == 4'b1000, "R9 capture after full delay",
              {3'b0, cap_strobe, mode_code}, 8'h18);

        // R1 park after capture clears immediately
        park(1);
        check(tp_oe == 0 && mode_code == 0 && tp_out == 0, "R1 park clears", tp_out, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule